// File: doc/BRIEF.md
# Matrix Index Remap Generator

This block sits between a vector loop sequencer and the element datapath. The loop itself counts from step 0 up to VL-1. For each accepted step, the block returns the element index that the step should use under a 32-bit shape word. The word describes the data as a 3D array with x, y and z extents. The three axes can be nested in any of six loop orders, and each axis can count downward instead of upward. One loop level can be left out of the index, which gives repeated or modulo sequences. A small offset is added to every index. Extents need not be powers of two.

Usage is simple. The control logic pulses `start_i` with the shape word and the vector length. It then raises `step_i` on each cycle it wants an index. One registered index comes back per accepted step. `done_o` rises together with the final index and stays high until the next start. Once the index order has wrapped through the whole array, it repeats for as long as steps remain.

Top module: `mtx_remap_gen`

## Requirements
- R1: After reset, `idx_valid_o` and `done_o` are low.
- R2: `start_i` captures `shape_i` and `vl_i` and returns every axis to its start value. On the next cycle `idx_valid_o` is low. `done_o` is then low, unless `vl_i` was 0, in which case it is high.
- R3: A step is accepted when `step_i` is high, `start_i` is low, and the current run still has steps left. `idx_valid_o` is high on exactly the cycles that follow an accepted step.
- R4: `done_o` rises on the same cycle as the VL-th valid index. It then stays high until the next start, and further steps produce no valid index.
- R5: The axis extents are x = shape[5:0]+1, y = shape[11:6]+1 and z = shape[17:12]+1. With no axis skipped, the index is x_val + y_val·X + z_val·X·Y.
- R6: shape[20:18] picks the loop order, listed innermost axis first (0=x, 1=y, 2=z). The codes are 000:(x,y,z), 001:(x,z,y), 010:(y,x,z), 011:(y,z,x), 100:(z,x,y) and 101:(z,y,x). The innermost axis advances on every step, and an outer axis advances only when all axes inside it wrap.
- R7: shape[21], shape[22] and shape[23] reverse the x, y and z axes. A reversed axis runs from extent-1 down to 0.
- R8: shape[29:28] = k, with k not 0, drops loop level k from the index, where level 1 is the innermost. The dropped axis keeps counting. It contributes no term to the index and no factor to the weights of the axes kept. Each kept axis is weighted by the product of the extents of the kept axes below it, in x, y, z order. A value of 0 drops nothing.
- R9: shape[27:24] is added to every index.
- R10: A shape word of all zeros makes each index equal to its step number.
- R11: If VL exceeds X·Y·Z, the counters wrap back to their start values and the index sequence repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new run with the shape word and length presented |
| shape_i | input | 32 | Matrix shape word |
| vl_i | input | VL_W | Number of steps in the run |
| step_i | input | 1 | Request one index |
| idx_o | output | IDX_W | Remapped element index |
| idx_valid_o | output | 1 | idx_o holds a fresh index |
| done_o | output | 1 | All VL steps of the run have been issued |

## Verification
The bench uses the default parameters: a 7-bit length, so runs of up to 127 steps, and 6-bit extents, so a 19-bit index. With these settings it can run every loop order on a 3×2×4 array. Lengths longer than the array product take the counters through their wrap. Arrays with extents of 1, 2 and 3 show each skip level as both a repeat and a modulo pattern. A direction model built from division and remainder on the step number is compared against every index.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
  localparam int SHAPE_W = 32;
  localparam int FLD_W   = 6;
  localparam int OFS_W   = 4;

  typedef struct packed {
    logic [1:0]       mode;
    logic [1:0]       skip;
    logic [OFS_W-1:0] ofs;
    logic [2:0]       inv;
    logic [2:0]       perm;
    logic [FLD_W-1:0] zlast;
    logic [FLD_W-1:0] ylast;
    logic [FLD_W-1:0] xlast;
  } shape_t;

  // Loop order packed as {outer, middle, inner}, two bits per axis id.
  function automatic logic [5:0] loop_order(input logic [2:0] perm);
    case (perm)
      3'd1:    return {2'd1, 2'd2, 2'd0};
      3'd2:    return {2'd2, 2'd0, 2'd1};
      3'd3:    return {2'd0, 2'd2, 2'd1};
      3'd4:    return {2'd1, 2'd0, 2'd2};
      3'd5:    return {2'd0, 2'd1, 2'd2};
      default: return {2'd2, 2'd1, 2'd0};
    endcase
  endfunction

  function automatic logic [1:0] level_of(input logic [5:0] ord, input logic [1:0] ax);
    if (ord[1:0] == ax)      return 2'd0;
    else if (ord[3:2] == ax) return 2'd1;
    else                     return 2'd2;
  endfunction
endpackage

// File: rtl/mrg_shape_dec.sv
module mrg_shape_dec
  import mrg_pkg::*;
(
  input  logic [SHAPE_W-1:0]         shape_i,
  output logic [2:0][FLD_W-1:0]      last_o,
  output logic [2:0]                 inv_o,
  output logic [5:0]                 order_o,
  output logic [2:0]                 keep_o,
  output logic [OFS_W-1:0]           ofs_o,
  output logic                       linear_o
);
  shape_t sh;
  logic [1:0] drop_ax;

  always_comb begin
    sh       = shape_t'(shape_i);
    last_o   = {sh.zlast, sh.ylast, sh.xlast};
    inv_o    = sh.inv;
    order_o  = loop_order(sh.perm);
    ofs_o    = sh.ofs;
    linear_o = (shape_i == '0);
    keep_o   = 3'b111;
    drop_ax  = 2'd0;
    if (sh.skip != 2'd0) begin
      case (sh.skip)
        2'd1:    drop_ax = order_o[1:0];
        2'd2:    drop_ax = order_o[3:2];
        default: drop_ax = order_o[5:4];
      endcase
      keep_o[drop_ax] = 1'b0;
    end
  end
endmodule

// File: rtl/mrg_axis_ctr.sv
module mrg_axis_ctr #(
  parameter int DIM_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [DIM_W-1:0] last_i,
  output logic [DIM_W-1:0] pos_o,
  output logic             wrap_o
);
  assign wrap_o = (pos_o == last_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_o <= '0;
    else if (clr_i)  pos_o <= '0;
    else if (adv_i)  pos_o <= wrap_o ? '0 : pos_o + 1'b1;
  end
endmodule

// File: rtl/mrg_idx_comp.sv
module mrg_idx_comp
  import mrg_pkg::*;
#(
  parameter int VL_W  = 7,
  parameter int IDX_W = 3*FLD_W + 1
) (
  input  logic [2:0][FLD_W-1:0] pos_i,
  input  logic [2:0][FLD_W-1:0] last_i,
  input  logic [2:0]            inv_i,
  input  logic [2:0]            keep_i,
  input  logic [OFS_W-1:0]      ofs_i,
  input  logic                  linear_i,
  input  logic [VL_W-1:0]       step_no_i,
  output logic [IDX_W-1:0]      idx_o
);
  function automatic logic [IDX_W-1:0] axis_val(input logic [FLD_W-1:0] p,
                                                input logic [FLD_W-1:0] l,
                                                input logic rev);
    return rev ? IDX_W'(l - p) : IDX_W'(p);
  endfunction

  function automatic logic [IDX_W-1:0] extent(input logic [FLD_W-1:0] l, input logic kept);
    return kept ? IDX_W'(l) + 1'b1 : IDX_W'(1);
  endfunction

  logic [2:0][IDX_W-1:0] val, wgt;
  logic [IDX_W-1:0]      sum;

  always_comb begin
    for (int a = 0; a < 3; a++) val[a] = axis_val(pos_i[a], last_i[a], inv_i[a]);
    wgt[0] = IDX_W'(1);
    wgt[1] = extent(last_i[0], keep_i[0]);
    wgt[2] = IDX_W'(wgt[1] * extent(last_i[1], keep_i[1]));
    sum = IDX_W'(ofs_i);
    for (int a = 0; a < 3; a++)
      if (keep_i[a]) sum = sum + IDX_W'(val[a] * wgt[a]);
    idx_o = linear_i ? IDX_W'(step_no_i) : sum;
  end
endmodule

// File: rtl/mtx_remap_gen.sv
module mtx_remap_gen
  import mrg_pkg::*;
#(
  parameter int VL_W  = 7,
  parameter int IDX_W = 3*FLD_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [31:0]        shape_i,
  input  logic [VL_W-1:0]    vl_i,
  input  logic               step_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               idx_valid_o,
  output logic               done_o
);
  logic [SHAPE_W-1:0]     shape_q;
  logic [VL_W-1:0]        vl_q, cnt_q;
  logic                   busy_q;
  logic                   fire_w, last_step_w;

  logic [2:0][FLD_W-1:0]  last_w, pos_w;
  logic [2:0]             inv_w, keep_w, wrap_w, adv_w;
  logic [5:0]             order_w;
  logic [OFS_W-1:0]       ofs_w;
  logic                   linear_w;
  logic [IDX_W-1:0]       idx_next_w;

  assign fire_w      = step_i && !start_i && busy_q;
  assign last_step_w = (cnt_q == vl_q - 1'b1);

  mrg_shape_dec dec_i (
    .shape_i (shape_q), .last_o (last_w), .inv_o (inv_w), .order_o (order_w),
    .keep_o (keep_w), .ofs_o (ofs_w), .linear_o (linear_w)
  );

  always_comb begin
    for (int a = 0; a < 3; a++) begin
      adv_w[a] = fire_w;
      for (int b = 0; b < 3; b++)
        if (b != a && level_of(order_w, 2'(b)) < level_of(order_w, 2'(a)))
          adv_w[a] = adv_w[a] & wrap_w[b];
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_axis
    mrg_axis_ctr #(.DIM_W(FLD_W)) ctr_i (
      .clk (clk), .rst_n (rst_n), .clr_i (start_i), .adv_i (adv_w[g]),
      .last_i (last_w[g]), .pos_o (pos_w[g]), .wrap_o (wrap_w[g])
    );
  end

  mrg_idx_comp #(.VL_W(VL_W), .IDX_W(IDX_W)) comp_i (
    .pos_i (pos_w), .last_i (last_w), .inv_i (inv_w), .keep_i (keep_w),
    .ofs_i (ofs_w), .linear_i (linear_w), .step_no_i (cnt_q), .idx_o (idx_next_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shape_q     <= '0;
      vl_q        <= '0;
      cnt_q       <= '0;
      busy_q      <= 1'b0;
      done_o      <= 1'b0;
      idx_valid_o <= 1'b0;
      idx_o       <= '0;
    end else begin
      idx_valid_o <= fire_w;
      if (fire_w) idx_o <= idx_next_w;
      if (start_i) begin
        shape_q <= shape_i;
        vl_q    <= vl_i;
        cnt_q   <= '0;
        busy_q  <= (vl_i != '0);
        done_o  <= (vl_i == '0);
      end else if (fire_w) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_step_w) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mtx_remap_gen_chk.sv
module mtx_remap_gen_chk #(
  parameter int VL_W  = 7,
  parameter int IDX_W = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [31:0]      shape_i,
  input logic [VL_W-1:0]  vl_i,
  input logic [IDX_W-1:0] idx_o,
  input logic             idx_valid_o,
  input logic             done_o,
  input logic             fire_w
);
  logic             lin_q;
  logic [3:0]       ofs_q;
  logic [IDX_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q <= 1'b0; ofs_q <= '0; seen_q <= '0;
    end else if (start_i) begin
      lin_q <= (shape_i == '0); ofs_q <= shape_i[27:24]; seen_q <= '0;
    end else if (idx_valid_o) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  // R3
  valid_follows_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> idx_valid_o == $past(fire_w));
  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o);
  // R4
  no_issue_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> !idx_valid_o);
  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !idx_valid_o && (done_o == ($past(vl_i) == '0)));
  // R10
  linear_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid_o && lin_q |-> idx_o == seen_q);
  // R9
  offset_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid_o && !lin_q |-> idx_o >= IDX_W'(ofs_q));
endmodule

bind mtx_remap_gen mtx_remap_gen_chk #(.VL_W(VL_W), .IDX_W(IDX_W)) chk_i (
  .clk (clk), .rst_n (rst_n), .start_i (start_i), .shape_i (shape_i), .vl_i (vl_i),
  .idx_o (idx_o), .idx_valid_o (idx_valid_o), .done_o (done_o), .fire_w (fire_w)
);

// File: tb/mtx_remap_gen_tb_top.sv
`timescale 1ns/1ps
module mtx_remap_gen_tb_top;
  localparam int VL_W  = 7;
  localparam int IDX_W = 19;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [31:0]      shape_i = '0;
  logic [VL_W-1:0]  vl_i = '0;
  logic             step_i = 1'b0;
  logic [IDX_W-1:0] idx_o;
  logic             idx_valid_o, done_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  mtx_remap_gen #(.VL_W(VL_W), .IDX_W(IDX_W)) dut_i (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .shape_i (shape_i), .vl_i (vl_i),
    .step_i (step_i), .idx_o (idx_o), .idx_valid_o (idx_valid_o), .done_o (done_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int perm, input int inv, input int skip,
                                     input int ofs, input int xs, input int ys, input int zs);
    return {2'b00, 2'(skip), 4'(ofs), 3'(inv), 3'(perm), 6'(zs - 1), 6'(ys - 1), 6'(xs - 1)};
  endfunction

  // Independent model: decompose the step number over the loop order by division.
  function automatic int model(input logic [31:0] sh, input int i);
    int sz[3], ord[3], p[3], v[3], idx, w, drop;
    if (sh == 0) return i;
    sz[0] = sh[5:0] + 1; sz[1] = sh[11:6] + 1; sz[2] = sh[17:12] + 1;
    case (sh[20:18])
      3'd0: ord = '{0, 1, 2};
      3'd1: ord = '{0, 2, 1};
      3'd2: ord = '{1, 0, 2};
      3'd3: ord = '{1, 2, 0};
      3'd4: ord = '{2, 0, 1};
      default: ord = '{2, 1, 0};
    endcase
    p[ord[0]] = i % sz[ord[0]];
    p[ord[1]] = (i / sz[ord[0]]) % sz[ord[1]];
    p[ord[2]] = (i / (sz[ord[0]] * sz[ord[1]])) % sz[ord[2]];
    for (int a = 0; a < 3; a++) v[a] = sh[21 + a] ? sz[a] - 1 - p[a] : p[a];
    drop = (sh[29:28] == 0) ? -1 : ord[sh[29:28] - 1];
    idx = sh[27:24]; w = 1;
    for (int a = 0; a < 3; a++)
      if (a != drop) begin idx += v[a] * w; w *= sz[a]; end
    return idx;
  endfunction

  task automatic begin_run(input logic [31:0] sh, input int vl);
    @(negedge clk);
    shape_i = sh; vl_i = VL_W'(vl); start_i = 1'b1; step_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Steps through a run, idling one cycle between steps when gap is set.
  task automatic run_seq(input logic [31:0] sh, input int vl, input bit gap, input string req);
    begin_run(sh, vl);
    chk(done_o == 1'b0 && idx_valid_o == 1'b0, {req, "/R2 start state"}, done_o, 0);
    for (int i = 0; i < vl; i++) begin
      step_i = 1'b1;
      @(negedge clk);
      step_i = 1'b0;
      chk(idx_valid_o == 1'b1, {req, "/R3 valid"}, idx_valid_o, 1);
      chk(idx_o == IDX_W'(model(sh, i)), req, idx_o, model(sh, i));
      chk(done_o == (i == vl - 1), {req, "/R4 done timing"}, done_o, i == vl - 1);
      if (gap) begin
        @(negedge clk);
        chk(idx_valid_o == 1'b0, {req, "/R3 idle gap"}, idx_valid_o, 0);
      end
    end
  endtask

  task automatic t_reset;
    chk(idx_valid_o == 1'b0 && done_o == 1'b0, "R1 reset", {idx_valid_o, done_o}, 0);
  endtask

  task automatic t_plain;
    run_seq(mk(0, 0, 0, 0, 3, 2, 2), 12, 1'b0, "R5 plain 3x2x2");
  endtask

  task automatic t_perms;
    for (int p = 0; p < 6; p++) run_seq(mk(p, 0, 0, 0, 3, 2, 4), 24, 1'b0, "R6 order");
  endtask

  task automatic t_invert;
    run_seq(mk(0, 1, 0, 0, 3, 2, 2), 12, 1'b0, "R7 reverse x");
    run_seq(mk(2, 6, 0, 0, 3, 2, 2), 12, 1'b0, "R7 reverse yz");
    run_seq(mk(5, 7, 0, 0, 2, 3, 2), 12, 1'b0, "R7 reverse all");
  endtask

  task automatic t_skip;
    run_seq(mk(0, 0, 1, 0, 3, 3, 1), 9, 1'b0, "R8 repeat");
    run_seq(mk(0, 0, 2, 0, 3, 3, 1), 9, 1'b0, "R8 modulo");
    run_seq(mk(3, 2, 3, 0, 2, 3, 2), 12, 1'b0, "R8 drop outer");
    run_seq(mk(4, 0, 2, 0, 2, 3, 3), 18, 1'b0, "R8 drop middle");
  endtask

  task automatic t_offset;
    run_seq(mk(1, 4, 0, 15, 2, 2, 3), 12, 1'b0, "R9 offset");
  endtask

  task automatic t_linear;
    run_seq(32'h0, 20, 1'b1, "R10 linear");
  endtask

  task automatic t_wrap;
    run_seq(mk(2, 1, 0, 3, 2, 3, 1), 20, 1'b0, "R11 wrap");
    run_seq(mk(0, 0, 0, 0, 5, 5, 5), 127, 1'b0, "R11 full length");
  endtask

  task automatic t_after_done;
    run_seq(mk(0, 0, 0, 0, 2, 2, 1), 4, 1'b0, "R4 short");
    step_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(idx_valid_o == 1'b0, "R4 step ignored after done", idx_valid_o, 0);
      chk(done_o == 1'b1, "R4 done held", done_o, 1);
    end
    step_i = 1'b0;
    begin_run(mk(0, 0, 0, 0, 2, 2, 1), 0);
    chk(done_o == 1'b1, "R2 zero length done", done_o, 1);
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    chk(idx_valid_o == 1'b0, "R2 zero length no index", idx_valid_o, 0);
  endtask

  task automatic finish_up;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_perms();
    t_invert();
    t_skip();
    t_offset();
    t_linear();
    t_wrap();
    t_after_done();
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_up();
  end
endmodule